// File: doc/BRIEF.md
# Sector-Programmed Parallel Flash Controller

This block is the device-side control logic of a byte-wide parallel flash memory that is rewritten one whole sector at a time. Three active-low strobes (chip select, write strobe and output strobe) are brought into the system clock domain and edge-detected. From them the block decodes two bus actions: reads, which return stored bytes, and byte loads, which place a byte into a holding buffer for one sector. A load is active while chip select and write strobe are both low and the output strobe is high. The address is taken when that condition begins, which is the later of the two falling strobe edges. The data is taken when it ends, which is the earlier of the two rising edges.

Loads may arrive in any order. The first accepted load fixes the sector. After each accepted load ends, an inactivity timer runs. If no further accepted load begins before the timer expires, the block closes the load window and starts a timed internal cycle. That cycle first erases the whole sector and then writes every buffered byte into the storage array. While the cycle runs, the external bus is free. A read during the cycle returns a status pattern instead of array data, so that software can poll for completion. The storage array is a plain synchronous memory model that comes up erased.

Top module: `spe_sector_engine`

## Requirements
- R1: When chip select and output strobe are low and the write strobe is high, with no internal cycle running, `dout_oe` is 1 and `dout` equals the stored byte at `addr`, within 6 clock cycles.
- R2: Whenever chip select or the output strobe is high, `dout_oe` is 0 and `dout` is 0 (after the synchroniser delay).
- R3: A load is performed either by a write-strobe pulse while chip select is low, or by a chip-select pulse while the write strobe is low, with the output strobe high in both cases. The address is the one present when the later of the two strobes falls. The data is the one present when the earlier of the two strobes rises.
- R4: Loads whose start comes less than `WIN_CYC` cycles after the previous accepted load ended join the same program cycle. If `WIN_CYC` cycles pass with no new accepted load, the program cycle starts.
- R5: Address bits `[SEC_W+BYTE_W-1:BYTE_W]` select the sector and bits `[BYTE_W-1:0]` select the byte. Bytes may be loaded in any order. After programming, bytes of the sector that were not loaded read 0xFF, and other sectors are unchanged.
- R6: The program cycle erases the whole sector to 0xFF before it writes the buffered bytes, so earlier contents of the sector do not survive.
- R7: While the program cycle runs (`PROG_CYC` cycles from its start), a read returns bit `DATA_W-1` as the complement of that bit of the last accepted byte, with all other bits 0. After the cycle, reads return true data.
- R8: Loads that begin while a program cycle runs are ignored.
- R9: Within one load window, a load to a sector other than the one fixed by the first load is ignored and does not extend the window.
- R10: After reset, `dout_oe` and `dout` are 0, no cycle is running, and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | SEC_W+BYTE_W (10) | Byte address: sector field above byte field |
| din | input | DATA_W (8) | Write data bus |
| dout | output | DATA_W (8) | Read data, 0 when not driven |
| dout_oe | output | 1 | Read data bus drive enable |

## Verification
The hardest conditions to create are the two edge-selection rules. The address must come from the later falling strobe and the data from the earlier rising strobe. Loads must also be dropped while the internal cycle runs or when they name a foreign sector. To reach these, the stimulus staggers the two strobes by several cycles and changes the address or data bus between the staggered edges. It then sends extra loads after the timer has expired, and foreign-sector loads inside a live window. Every outcome is read back through ordinary reads once the cycle has finished, and polling reads taken in mid-cycle confirm the status pattern for both values of the top data bit.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ERASE = 2'd1,
    SQ_PROG  = 2'd2,
    SQ_HOLD  = 2'd3
  } seq_state_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/spe_strobe_sync.sv
module spe_strobe_sync #(
  parameter int AW     = 10,
  parameter int DW     = 8,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_start,
  output logic          wr_end,
  output logic          rd_act,
  output logic [AW-1:0] addr_s,
  output logic [DW-1:0] din_last
);
  logic [SYNC_N-1:0] ce_sh, we_sh, oe_sh;
  logic [AW-1:0]     a_sh [SYNC_N];
  logic [DW-1:0]     d_sh [SYNC_N+1];
  logic              wr_act, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_sh <= '1;
      we_sh <= '1;
      oe_sh <= '1;
      wr_q  <= 1'b0;
    end else begin
      ce_sh <= {ce_sh[SYNC_N-2:0], ce_n};
      we_sh <= {we_sh[SYNC_N-2:0], we_n};
      oe_sh <= {oe_sh[SYNC_N-2:0], oe_n};
      wr_q  <= wr_act;
    end
  end

  // bus pipelines kept aligned with the strobe synchronisers
  always_ff @(posedge clk) begin
    a_sh[0] <= addr;
    d_sh[0] <= din;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_N; g++) begin : g_abus
      always_ff @(posedge clk) a_sh[g] <= a_sh[g-1];
    end
    for (g = 1; g <= SYNC_N; g++) begin : g_dbus
      always_ff @(posedge clk) d_sh[g] <= d_sh[g-1];
    end
  endgenerate

  assign wr_act   = !ce_sh[SYNC_N-1] && !we_sh[SYNC_N-1] && oe_sh[SYNC_N-1];
  assign rd_act   = !ce_sh[SYNC_N-1] && !oe_sh[SYNC_N-1] && we_sh[SYNC_N-1];
  assign wr_start = wr_act && !wr_q;
  assign wr_end   = !wr_act && wr_q;
  assign addr_s   = a_sh[SYNC_N-1];
  assign din_last = d_sh[SYNC_N];   // last sample taken while the load was active
endmodule

// File: rtl/spe_load_ctrl.sv
module spe_load_ctrl #(
  parameter int SEC_W   = 2,
  parameter int BYTE_W  = 8,
  parameter int DATA_W  = 8,
  parameter int WIN_CYC = 7500
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_start,
  input  logic                    wr_end,
  input  logic [SEC_W+BYTE_W-1:0] addr_s,
  input  logic [DATA_W-1:0]       din_last,
  input  logic                    busy,
  input  logic                    done,
  input  logic [BYTE_W-1:0]       buf_raddr,
  output logic                    start,
  output logic [SEC_W-1:0]        win_sec,
  output logic                    last_msb,
  output logic [DATA_W-1:0]       buf_rdata,
  output logic                    buf_rvalid,
  output logic                    buf_we,
  output logic [$clog2(WIN_CYC+1)-1:0] win_cnt
);
  localparam int NBYTES = 1 << BYTE_W;
  localparam int CW     = $clog2(WIN_CYC+1);
  localparam logic [CW-1:0] CNT_LAST = CW'(WIN_CYC - 1);

  logic [DATA_W-1:0] hold_mem [NBYTES];
  logic [NBYTES-1:0] loaded;
  logic              win_open, acc_q;
  logic [BYTE_W-1:0] byte_q;
  logic [SEC_W-1:0]  sec_in;
  logic              accept;

  assign sec_in = addr_s[SEC_W+BYTE_W-1:BYTE_W];
  assign accept = wr_start && !busy && !start && (!win_open || sec_in == win_sec);
  assign buf_we = wr_end && acc_q && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open   <= 1'b0;
      win_sec    <= '0;
      acc_q      <= 1'b0;
      byte_q     <= '0;
      win_cnt    <= '0;
      start      <= 1'b0;
      last_msb   <= 1'b0;
      loaded     <= '0;
      buf_rvalid <= 1'b0;
    end else begin
      start      <= 1'b0;
      buf_rvalid <= loaded[buf_raddr];
      if (done) begin
        win_open <= 1'b0;
        loaded   <= '0;
        win_cnt  <= '0;
        acc_q    <= 1'b0;
      end else begin
        if (wr_start) begin
          acc_q  <= accept;
          byte_q <= addr_s[BYTE_W-1:0];
        end
        if (accept) begin
          win_cnt <= '0;
          if (!win_open) begin
            win_open <= 1'b1;
            win_sec  <= sec_in;
          end
        end else if (buf_we) begin
          loaded[byte_q] <= 1'b1;
          last_msb       <= din_last[DATA_W-1];
          acc_q          <= 1'b0;
          win_cnt        <= '0;
        end else if (win_open && !acc_q && !busy && !start) begin
          if (win_cnt == CNT_LAST) begin
            start   <= 1'b1;
            win_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
      end
    end
  end

  // holding buffer: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (buf_we) hold_mem[byte_q] <= din_last;
    buf_rdata <= hold_mem[buf_raddr];
  end
endmodule

// File: rtl/spe_prog_seq.sv
module spe_prog_seq
  import spe_pkg::*;
#(
  parameter int SEC_W    = 2,
  parameter int BYTE_W   = 8,
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 500000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [SEC_W-1:0]        win_sec,
  input  logic [DATA_W-1:0]       buf_rdata,
  input  logic                    buf_rvalid,
  output logic                    busy,
  output logic                    done,
  output logic [BYTE_W-1:0]       buf_raddr,
  output logic                    arr_we,
  output logic [SEC_W+BYTE_W-1:0] arr_waddr,
  output logic [DATA_W-1:0]       arr_wdata
);
  localparam int PW = $clog2(PROG_CYC+1);
  localparam logic [PW-1:0]     CYC_LAST = PW'(PROG_CYC - 1);
  localparam logic [BYTE_W-1:0] IDX_LAST = '1;

  seq_state_t        state;
  logic [BYTE_W-1:0] idx, idx_q;
  logic              pv;
  logic [PW-1:0]     cyc;

  assign buf_raddr = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      idx       <= '0;
      idx_q     <= '0;
      pv        <= 1'b0;
      cyc       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      arr_we    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
    end else begin
      done   <= 1'b0;
      arr_we <= 1'b0;
      pv     <= (state == SQ_PROG);
      idx_q  <= idx;
      if (busy) cyc <= cyc + 1'b1;
      if (pv && buf_rvalid) begin
        arr_we    <= 1'b1;
        arr_waddr <= {win_sec, idx_q};
        arr_wdata <= buf_rdata;
      end
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state <= SQ_ERASE;
            busy  <= 1'b1;
            cyc   <= '0;
            idx   <= '0;
          end
        end
        SQ_ERASE: begin
          arr_we    <= 1'b1;
          arr_waddr <= {win_sec, idx};
          arr_wdata <= DATA_W'(ERASED_BYTE);
          idx       <= idx + 1'b1;
          if (idx == IDX_LAST) state <= SQ_PROG;
        end
        SQ_PROG: begin
          idx <= idx + 1'b1;
          if (idx == IDX_LAST) state <= SQ_HOLD;
        end
        default: begin
          if (cyc >= CYC_LAST) begin
            state <= SQ_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spe_array.sv
module spe_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/spe_sector_engine.sv
module spe_sector_engine #(
  parameter int SEC_W    = 2,
  parameter int BYTE_W   = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_CYC  = 7500,
  parameter int PROG_CYC = 500000,
  parameter int SYNC_N   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [SEC_W+BYTE_W-1:0] addr,
  input  logic [DATA_W-1:0]       din,
  output logic [DATA_W-1:0]       dout,
  output logic                    dout_oe
);
  localparam int AW = SEC_W + BYTE_W;
  localparam int CW = $clog2(WIN_CYC+1);

  logic              wr_start, wr_end, rd_act;
  logic [AW-1:0]     addr_s;
  logic [DATA_W-1:0] din_last;
  logic              start, busy, done, last_msb;
  logic [SEC_W-1:0]  win_sec;
  logic [DATA_W-1:0] buf_rdata, mem_q;
  logic              buf_rvalid, buf_we;
  logic [BYTE_W-1:0] buf_raddr;
  logic              arr_we;
  logic [AW-1:0]     arr_waddr;
  logic [DATA_W-1:0] arr_wdata;
  logic [CW-1:0]     win_cnt;

  spe_strobe_sync #(.AW(AW), .DW(DATA_W), .SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_start(wr_start), .wr_end(wr_end),
    .rd_act(rd_act), .addr_s(addr_s), .din_last(din_last)
  );

  spe_load_ctrl #(.SEC_W(SEC_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W),
                  .WIN_CYC(WIN_CYC)) u_load (
    .clk(clk), .rst(rst), .wr_start(wr_start), .wr_end(wr_end),
    .addr_s(addr_s), .din_last(din_last), .busy(busy), .done(done),
    .buf_raddr(buf_raddr), .start(start), .win_sec(win_sec),
    .last_msb(last_msb), .buf_rdata(buf_rdata), .buf_rvalid(buf_rvalid),
    .buf_we(buf_we), .win_cnt(win_cnt)
  );

  spe_prog_seq #(.SEC_W(SEC_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W),
                 .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .win_sec(win_sec),
    .buf_rdata(buf_rdata), .buf_rvalid(buf_rvalid), .busy(busy),
    .done(done), .buf_raddr(buf_raddr), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  spe_array #(.AW(AW), .DW(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(addr_s), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_act;
      if (!rd_act)   dout <= '0;
      else if (busy) dout <= {~last_msb, {(DATA_W-1){1'b0}}};
      else           dout <= mem_q;
    end
  end
endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
  parameter int SEC_W   = 2,
  parameter int BYTE_W  = 8,
  parameter int DATA_W  = 8,
  parameter int WIN_CYC = 7500
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce_n,
  input logic                    dout_oe,
  input logic [DATA_W-1:0]       dout,
  input logic                    busy,
  input logic                    buf_we,
  input logic                    arr_we,
  input logic [SEC_W+BYTE_W-1:0] arr_waddr,
  input logic [SEC_W-1:0]        win_sec,
  input logic [$clog2(WIN_CYC+1)-1:0] win_cnt
);
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_n, 2) && $past(ce_n, 3) && $past(ce_n, 4)) |-> (!dout_oe && dout == '0));

  a_r8_no_load_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !buf_we);

  a_r7_poll_pattern: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && dout_oe) |-> dout[DATA_W-2:0] == '0);

  a_r6_writes_stay_in_sector: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> arr_waddr[SEC_W+BYTE_W-1:BYTE_W] == win_sec);

  a_r4_window_bounded: assert property (@(posedge clk) disable iff (rst)
    win_cnt < ($clog2(WIN_CYC+1))'(WIN_CYC));

  a_r9_array_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> !arr_we);
endmodule

bind spe_sector_engine spe_checker #(
  .SEC_W(SEC_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W), .WIN_CYC(WIN_CYC)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .dout_oe(dout_oe), .dout(dout),
  .busy(busy), .buf_we(buf_we), .arr_we(arr_we), .arr_waddr(arr_waddr),
  .win_sec(win_sec), .win_cnt(win_cnt)
);

// File: tb/tb_spe_sector_engine.sv
module tb_spe_sector_engine;
  localparam int SEC_W = 2, BYTE_W = 8, DATA_W = 8;
  localparam int WIN_CYC = 40, PROG_CYC = 1000;
  localparam int AW = SEC_W + BYTE_W;

  logic clk = 0, rst = 1;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_oe;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spe_sector_engine #(.SEC_W(SEC_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W),
    .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // write-strobe controlled load
  task automatic load_we(logic [AW-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    oe_n = 1; ce_n = 0; addr = a; din = d;
    cyc(4); we_n = 0; cyc(4); we_n = 1; cyc(4); ce_n = 1; cyc(2);
  endtask

  task automatic read(logic [AW-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    we_n = 1; ce_n = 0; oe_n = 0; addr = a;
    cyc(6);
    d = dout;
    ce_n = 1; oe_n = 1;
    cyc(3);
  endtask

  task automatic expect_byte(string req, logic [AW-1:0] a, logic [DATA_W-1:0] e);
    logic [DATA_W-1:0] d;
    read(a, d);
    check(req, {8'h0, d}, {8'h0, e});
  endtask

  task automatic wait_cycle_end();
    cyc(WIN_CYC + PROG_CYC + 60);
  endtask

  task automatic t_reset();
    check("R10 dout_oe after reset", {15'h0, dout_oe}, 16'h0);
    check("R10 dout after reset", {8'h0, dout}, 16'h0);
    expect_byte("R10 erased array", 10'h005, 8'hFF);
    expect_byte("R10 erased array hi", 10'h3FF, 8'hFF);
  endtask

  task automatic t_bus_control();
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; addr = 10'h020;
    cyc(6);
    check("R1 drive enable on read", {15'h0, dout_oe}, 16'h1);
    check("R1 read data", {8'h0, dout}, 16'h00FF);
    oe_n = 1; cyc(6);
    check("R2 oe high releases bus", {15'h0, dout_oe}, 16'h0);
    check("R2 oe high data zero", {8'h0, dout}, 16'h0);
    oe_n = 0; ce_n = 1; cyc(6);
    check("R2 ce high releases bus", {15'h0, dout_oe}, 16'h0);
    oe_n = 1; cyc(2);
  endtask

  task automatic t_order_window();
    load_we(10'h110, 8'hA5);
    load_we(10'h103, 8'h3C);
    cyc(WIN_CYC - 15);            // rise-to-next-fall still inside the window
    load_we(10'h1FF, 8'h81);
    wait_cycle_end();
    expect_byte("R5 byte 0x10", 10'h110, 8'hA5);
    expect_byte("R5 byte 0x03 out of order", 10'h103, 8'h3C);
    expect_byte("R4 late-in-window byte joined", 10'h1FF, 8'h81);
    expect_byte("R5 unloaded byte", 10'h111, 8'hFF);
    expect_byte("R5 other sector untouched", 10'h010, 8'hFF);
  endtask

  task automatic t_poll_and_busy();
    logic [DATA_W-1:0] d;
    load_we(10'h200, 8'h7F);
    cyc(WIN_CYC + 20);
    read(10'h200, d);
    check("R7 poll while programming, msb 0 loaded", {8'h0, d}, 16'h0080);
    load_we(10'h2AA, 8'h12);      // during the cycle: must be dropped
    wait_cycle_end();
    expect_byte("R7 true data after cycle", 10'h200, 8'h7F);
    expect_byte("R8 load during cycle ignored", 10'h2AA, 8'hFF);
  endtask

  task automatic t_foreign_sector();
    load_we(10'h050, 8'h66);
    load_we(10'h150, 8'h77);
    wait_cycle_end();
    expect_byte("R9 first-sector byte kept", 10'h050, 8'h66);
    expect_byte("R9 foreign sector load ignored", 10'h150, 8'hFF);
  endtask

  task automatic t_strobe_edges();
    logic [DATA_W-1:0] d;
    // chip-select controlled load, write strobe held low
    @(negedge clk);
    oe_n = 1; we_n = 0; addr = 10'h3A0; din = 8'h5A;
    cyc(4); ce_n = 0; cyc(4); ce_n = 1; cyc(4); we_n = 1; cyc(4);
    // address from the later falling edge, data from the earlier rising edge
    ce_n = 0; addr = 10'h3B0; din = 8'hC3; cyc(4);
    addr = 10'h3B1; cyc(4);
    we_n = 0; cyc(4);
    we_n = 1; cyc(4);
    din = 8'h00; cyc(4);
    ce_n = 1; cyc(2);
    cyc(WIN_CYC + 20);
    read(10'h3B1, d);
    check("R7 poll while programming, msb 1 loaded", {8'h0, d}, 16'h0000);
    wait_cycle_end();
    expect_byte("R3 chip-select pulse load", 10'h3A0, 8'h5A);
    expect_byte("R3 address at later falling edge", 10'h3B1, 8'hC3);
    expect_byte("R3 earlier address not written", 10'h3B0, 8'hFF);
  endtask

  task automatic t_erase_first();
    load_we(10'h103, 8'h00);
    wait_cycle_end();
    expect_byte("R6 new byte programmed", 10'h103, 8'h00);
    expect_byte("R6 old byte erased", 10'h110, 8'hFF);
    expect_byte("R6 old top byte erased", 10'h1FF, 8'hFF);
  endtask

  initial begin
    cyc(5);
    rst = 0;
    cyc(3);
    t_reset();
    t_bus_control();
    t_order_window();
    t_poll_and_busy();
    t_foreign_sector();
    t_strobe_edges();
    t_erase_first();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule